// File: doc/BRIEF.md
# Working Register File with Pointer Pairs

This block holds the general working registers of a small 8-bit RISC core: 32 registers of 8 bits each. The execute stage uses two independent byte read ports, a byte write port, a 16-bit pair read port and a 16-bit pair write port. Reads are combinational from the stored state. Every write lands on the next rising clock edge, so an operand read and its result write can share one cycle.

The six highest registers also serve as three 16-bit indirect address pointers. A pointer port forms an effective address from a selected pointer. It can leave the pointer as it is, add a small unsigned displacement, step the pointer up after use, or step it down before use. Any step is written back into the register pair at the same edge as the other writes.

The registers also occupy the lowest 32 byte addresses of the core's data space. A data-bus access in that window reads or writes a register. A data-bus access outside the window gets no response from this block. When several write sources hit the same byte in one cycle, a fixed priority decides which value is stored.

Top module: `gpr_file`

## Requirements
- R1: A synchronous active-high reset clears every register to 0x00 at the next rising edge.
- R2: The two byte read ports return the selected registers combinationally, and both ports may select any register. A read of a register that is being written in the same cycle returns the value held before that edge.
- R3: A byte write with `wr_en` high stores `wr_data` into register `wr_idx` at the next edge.
- R4: A pair write with `wr16_en` high and an even `wr16_idx` = k stores `wr16_data[7:0]` into register k and `wr16_data[15:8]` into register k+1 at the next edge.
- R5: A pair write with an odd `wr16_idx` drives `pair_err` high in the same cycle and changes no register. `pair_err` is low at all other times.
- R6: The pair read port clears bit 0 of `rd_w_idx` to get an even index k, then returns {register k+1, register k}.
- R7: Data-bus addresses 0x0000 to 0x001F map to registers 0 to 31. For such an address `dbus_hit` is 1, `dbus_rdata` shows the register, and `dbus_we` stores `dbus_wdata` at the next edge. For any higher address `dbus_hit` is 0, `dbus_rdata` is 0x00 and a write is ignored.
- R8: `ptr_sel` chooses the pointer: 0 is registers 26 (low byte) and 27 (high byte), 1 is 28/29, and 2 is 30/31. Code 3, or `ptr_en` low, gives `ptr_addr` = 0x0000 and no pointer update.
- R9: With `ptr_mode` 1 (post-increment), `ptr_addr` equals the pointer and the 16-bit pair becomes pointer+1 at the next edge. The carry passes from the low byte into the high byte, and 0xFFFF wraps to 0x0000.
- R10: With `ptr_mode` 2 (pre-decrement), `ptr_addr` equals pointer-1 and the pair becomes pointer-1 at the next edge. The borrow passes from the low byte into the high byte.
- R11: With `ptr_mode` 3, `ptr_addr` is the pointer plus the zero-extended 6-bit `ptr_disp`. With `ptr_mode` 0, `ptr_addr` is the pointer itself. In both modes the pointer is left unchanged.
- R12: When several sources write the same byte in one cycle, the priority from highest to lowest is: byte write, then pair write, then pointer update, then data-bus write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_a_idx | input | 5 | Read port A register index |
| rd_a_data | output | 8 | Read port A data |
| rd_b_idx | input | 5 | Read port B register index |
| rd_b_data | output | 8 | Read port B data |
| rd_w_idx | input | 5 | Pair read index (bit 0 ignored) |
| rd_w_data | output | 16 | Pair read data {high, low} |
| wr_en | input | 1 | Byte write enable |
| wr_idx | input | 5 | Byte write register index |
| wr_data | input | 8 | Byte write data |
| wr16_en | input | 1 | Pair write enable |
| wr16_idx | input | 5 | Pair write index, must be even |
| wr16_data | input | 16 | Pair write data |
| pair_err | output | 1 | Odd pair write index flagged |
| ptr_en | input | 1 | Pointer access enable |
| ptr_sel | input | 2 | Pointer select (0,1,2; 3 = none) |
| ptr_mode | input | 2 | 0 plain, 1 post-inc, 2 pre-dec, 3 displacement |
| ptr_disp | input | 6 | Unsigned displacement |
| ptr_addr | output | 16 | Effective address |
| dbus_addr | input | 16 | Data-space byte address |
| dbus_we | input | 1 | Data-bus write strobe |
| dbus_wdata | input | 8 | Data-bus write data |
| dbus_rdata | output | 8 | Data-bus read data |
| dbus_hit | output | 1 | Address falls in the register window |

## Verification
The read data, `pair_err`, `dbus_hit`, `dbus_rdata` and `ptr_addr` are combinational. The bench samples them 1 ns after it drives the inputs at a falling edge, before the next rising edge. Register contents and pointer steps take effect at the one rising edge that follows. The bench reads them back through the read ports at the next falling edge, which is exactly one register stage later. For the same-cycle old-value rule, the bench reads a register while the write to it is still pending, before that edge.

// File: rtl/gpr_pkg.sv
package gpr_pkg;

    localparam int GPR_NREG     = 32;
    localparam int GPR_DW       = 8;
    localparam int GPR_AW       = 16;
    localparam int GPR_DISPW    = 6;
    localparam int GPR_PTR_BASE = 26;

    typedef enum logic [1:0] {
        PSEL_LOW  = 2'd0,
        PSEL_MID  = 2'd1,
        PSEL_HIGH = 2'd2,
        PSEL_NONE = 2'd3
    } ptr_sel_e;

    typedef enum logic [1:0] {
        PM_PLAIN   = 2'd0,
        PM_POSTINC = 2'd1,
        PM_PREDEC  = 2'd2,
        PM_DISP    = 2'd3
    } ptr_mode_e;

    typedef struct packed {
        ptr_sel_e  sel;
        ptr_mode_e mode;
    } ptr_ctl_t;

    function automatic logic steps_pointer(input ptr_mode_e m);
        return (m == PM_POSTINC) || (m == PM_PREDEC);
    endfunction

endpackage

// File: rtl/gpr_ptr_unit.sv
module gpr_ptr_unit
    import gpr_pkg::*;
#(
    parameter int PW    = 16,
    parameter int DISPW = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  ptr_ctl_t         ctl,
    input  logic [PW-1:0]    cur,
    input  logic [DISPW-1:0] disp,
    output logic [PW-1:0]    addr,
    output logic [PW-1:0]    nval,
    output logic             upd
);

    localparam logic [PW-1:0] ONE = PW'(1);

    logic active;
    assign active = en && (ctl.sel != PSEL_NONE);

    always_comb begin
        addr = '0;
        nval = cur;
        upd  = 1'b0;
        if (active) begin
            case (ctl.mode)
                PM_PLAIN:   addr = cur;
                PM_POSTINC: begin
                    addr = cur;
                    nval = cur + ONE;
                end
                PM_PREDEC:  begin
                    addr = cur - ONE;
                    nval = cur - ONE;
                end
                PM_DISP:    addr = cur + {{(PW-DISPW){1'b0}}, disp};
                default:    addr = '0;
            endcase
            upd = steps_pointer(ctl.mode);
        end
    end

    AST_STEP_NONZERO: assert property (@(posedge clk) disable iff (rst)
        upd |-> (nval != cur)); // R9
    AST_NO_PTR_IDLE: assert property (@(posedge clk) disable iff (rst)
        !active |-> (addr == '0 && !upd)); // R8

endmodule

// File: rtl/gpr_dbus_port.sv
module gpr_dbus_port #(
    parameter int NREG = 32,
    parameter int DW   = 8,
    parameter int AW   = 16,
    parameter int IDXW = 5
) (
    input  logic [AW-1:0]           addr,
    input  logic                    we,
    input  logic [NREG-1:0][DW-1:0] regs,
    output logic                    hit,
    output logic [IDXW-1:0]         idx,
    output logic [DW-1:0]           rdata,
    output logic                    we_ok
);

    localparam logic [AW-1:0] WINDOW = AW'(NREG);

    assign hit   = addr < WINDOW;
    assign idx   = addr[IDXW-1:0];
    assign we_ok = we && hit;
    assign rdata = hit ? regs[idx] : '0;

endmodule

// File: rtl/gpr_write_merge.sv
module gpr_write_merge #(
    parameter int NREG = 32,
    parameter int DW   = 8,
    parameter int IDXW = 5
) (
    input  logic [NREG-1:0][DW-1:0] cur,
    input  logic                    b_en,
    input  logic [IDXW-1:0]         b_idx,
    input  logic [DW-1:0]           b_data,
    input  logic                    p_en,
    input  logic [IDXW-1:0]         p_idx,
    input  logic [2*DW-1:0]         p_data,
    input  logic                    u_en,
    input  logic [IDXW-1:0]         u_lo,
    input  logic [IDXW-1:0]         u_hi,
    input  logic [2*DW-1:0]         u_data,
    input  logic                    d_en,
    input  logic [IDXW-1:0]         d_idx,
    input  logic [DW-1:0]           d_data,
    output logic [NREG-1:0][DW-1:0] nxt
);

    logic [IDXW-1:0] p_hi;
    assign p_hi = p_idx | IDXW'(1);

    for (genvar i = 0; i < NREG; i++) begin : g_byte
        localparam logic [IDXW-1:0] ME = IDXW'(i);
        always_comb begin
            nxt[i] = cur[i];
            if (d_en && d_idx == ME) nxt[i] = d_data;
            if (u_en && u_lo == ME)  nxt[i] = u_data[DW-1:0];
            if (u_en && u_hi == ME)  nxt[i] = u_data[2*DW-1:DW];
            if (p_en && p_idx == ME) nxt[i] = p_data[DW-1:0];
            if (p_en && p_hi == ME)  nxt[i] = p_data[2*DW-1:DW];
            if (b_en && b_idx == ME) nxt[i] = b_data;
        end
    end

endmodule

// File: rtl/gpr_file.sv
module gpr_file
    import gpr_pkg::*;
#(
    parameter int NREG     = GPR_NREG,
    parameter int DW       = GPR_DW,
    parameter int AW       = GPR_AW,
    parameter int DISPW    = GPR_DISPW,
    parameter int PTR_BASE = GPR_PTR_BASE
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [$clog2(NREG)-1:0]  rd_a_idx,
    output logic [DW-1:0]            rd_a_data,
    input  logic [$clog2(NREG)-1:0]  rd_b_idx,
    output logic [DW-1:0]            rd_b_data,
    input  logic [$clog2(NREG)-1:0]  rd_w_idx,
    output logic [2*DW-1:0]          rd_w_data,
    input  logic                     wr_en,
    input  logic [$clog2(NREG)-1:0]  wr_idx,
    input  logic [DW-1:0]            wr_data,
    input  logic                     wr16_en,
    input  logic [$clog2(NREG)-1:0]  wr16_idx,
    input  logic [2*DW-1:0]          wr16_data,
    output logic                     pair_err,
    input  logic                     ptr_en,
    input  logic [1:0]               ptr_sel,
    input  logic [1:0]               ptr_mode,
    input  logic [DISPW-1:0]         ptr_disp,
    output logic [2*DW-1:0]          ptr_addr,
    input  logic [AW-1:0]            dbus_addr,
    input  logic                     dbus_we,
    input  logic [DW-1:0]            dbus_wdata,
    output logic [DW-1:0]            dbus_rdata,
    output logic                     dbus_hit
);

    localparam int IDXW = $clog2(NREG);
    localparam int PW   = 2 * DW;
    localparam logic [IDXW-1:0] PBASE = IDXW'(PTR_BASE);
    localparam logic [IDXW-1:0] IONE  = IDXW'(1);

    logic [NREG-1:0][DW-1:0] q, nxt;

    // Read ports
    logic [IDXW-1:0] w_lo;
    assign w_lo      = {rd_w_idx[IDXW-1:1], 1'b0};
    assign rd_a_data = q[rd_a_idx];
    assign rd_b_data = q[rd_b_idx];
    assign rd_w_data = {q[w_lo | IONE], q[w_lo]};

    // Pair write qualification
    logic wr16_ok;
    assign wr16_ok  = wr16_en && !wr16_idx[0];
    assign pair_err = wr16_en && wr16_idx[0];

    // Pointer access
    ptr_ctl_t        ctl;
    logic [IDXW-1:0] ptr_lo, ptr_hi;
    logic [PW-1:0]   ptr_cur, ptr_nval;
    logic            ptr_upd;

    assign ctl.sel  = ptr_sel_e'(ptr_sel);
    assign ctl.mode = ptr_mode_e'(ptr_mode);
    assign ptr_lo   = PBASE + IDXW'({ptr_sel, 1'b0});
    assign ptr_hi   = ptr_lo + IONE;
    assign ptr_cur  = {q[ptr_hi], q[ptr_lo]};

    gpr_ptr_unit #(.PW(PW), .DISPW(DISPW)) u_ptr (
        .clk  (clk),
        .rst  (rst),
        .en   (ptr_en),
        .ctl  (ctl),
        .cur  (ptr_cur),
        .disp (ptr_disp),
        .addr (ptr_addr),
        .nval (ptr_nval),
        .upd  (ptr_upd)
    );

    // Data-space window
    logic [IDXW-1:0] db_idx;
    logic            db_we_ok;

    gpr_dbus_port #(.NREG(NREG), .DW(DW), .AW(AW), .IDXW(IDXW)) u_dbus (
        .addr  (dbus_addr),
        .we    (dbus_we),
        .regs  (q),
        .hit   (dbus_hit),
        .idx   (db_idx),
        .rdata (dbus_rdata),
        .we_ok (db_we_ok)
    );

    // Write priority merge
    gpr_write_merge #(.NREG(NREG), .DW(DW), .IDXW(IDXW)) u_merge (
        .cur    (q),
        .b_en   (wr_en),
        .b_idx  (wr_idx),
        .b_data (wr_data),
        .p_en   (wr16_ok),
        .p_idx  (wr16_idx),
        .p_data (wr16_data),
        .u_en   (ptr_upd),
        .u_lo   (ptr_lo),
        .u_hi   (ptr_hi),
        .u_data (ptr_nval),
        .d_en   (db_we_ok),
        .d_idx  (db_idx),
        .d_data (dbus_wdata),
        .nxt    (nxt)
    );

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= nxt;
    end

    logic quiet_others;
    assign quiet_others = !wr_en && !wr16_en && !dbus_we;

    AST_BYTE_WRITE: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> q[$past(wr_idx)] == $past(wr_data)); // R3
    AST_ODD_PAIR_NOCHANGE: assert property (@(posedge clk) disable iff (rst)
        (pair_err && !wr_en && !ptr_en && !dbus_we) |=> $stable(q)); // R5
    AST_POSTINC_STEP: assert property (@(posedge clk) disable iff (rst)
        (ptr_en && ptr_sel != 2'd3 && ptr_mode == 2'd1 && quiet_others)
        |=> {q[$past(ptr_hi)], q[$past(ptr_lo)]} == PW'($past(ptr_addr) + PW'(1))); // R9
    AST_PREDEC_STEP: assert property (@(posedge clk) disable iff (rst)
        (ptr_en && ptr_sel != 2'd3 && ptr_mode == 2'd2 && quiet_others)
        |=> {q[$past(ptr_hi)], q[$past(ptr_lo)]} == $past(ptr_addr)); // R10
    AST_OUTSIDE_WINDOW: assert property (@(posedge clk) disable iff (rst)
        (!dbus_hit && dbus_we && !wr_en && !wr16_en && !ptr_en) |=> $stable(q)); // R7

endmodule

// File: tb/tb_gpr_file.sv
module tb_gpr_file;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [4:0]  rd_a_idx = '0, rd_b_idx = '0, rd_w_idx = '0;
    logic [7:0]  rd_a_data, rd_b_data;
    logic [15:0] rd_w_data;
    logic        wr_en = 1'b0;
    logic [4:0]  wr_idx = '0;
    logic [7:0]  wr_data = '0;
    logic        wr16_en = 1'b0;
    logic [4:0]  wr16_idx = '0;
    logic [15:0] wr16_data = '0;
    logic        pair_err;
    logic        ptr_en = 1'b0;
    logic [1:0]  ptr_sel = '0, ptr_mode = '0;
    logic [5:0]  ptr_disp = '0;
    logic [15:0] ptr_addr;
    logic [15:0] dbus_addr = '0;
    logic        dbus_we = 1'b0;
    logic [7:0]  dbus_wdata = '0;
    logic [7:0]  dbus_rdata;
    logic        dbus_hit;

    int checks = 0;
    int errors = 0;
    logic done = 1'b0;

    always #10 clk = ~clk;

    gpr_file dut (
        .clk(clk), .rst(rst),
        .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data),
        .rd_b_idx(rd_b_idx), .rd_b_data(rd_b_data),
        .rd_w_idx(rd_w_idx), .rd_w_data(rd_w_data),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
        .wr16_en(wr16_en), .wr16_idx(wr16_idx), .wr16_data(wr16_data),
        .pair_err(pair_err),
        .ptr_en(ptr_en), .ptr_sel(ptr_sel), .ptr_mode(ptr_mode),
        .ptr_disp(ptr_disp), .ptr_addr(ptr_addr),
        .dbus_addr(dbus_addr), .dbus_we(dbus_we), .dbus_wdata(dbus_wdata),
        .dbus_rdata(dbus_rdata), .dbus_hit(dbus_hit)
    );

    task automatic chk(input string req, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic edge_n();
        @(negedge clk);
    endtask

    task automatic clear_inputs();
        wr_en = 1'b0; wr16_en = 1'b0; ptr_en = 1'b0; dbus_we = 1'b0;
    endtask

    task automatic w8(input logic [4:0] i, input logic [7:0] v);
        wr_en = 1'b1; wr_idx = i; wr_data = v;
        edge_n();
        clear_inputs();
    endtask

    task automatic w16(input logic [4:0] i, input logic [15:0] v);
        wr16_en = 1'b1; wr16_idx = i; wr16_data = v;
        edge_n();
        clear_inputs();
    endtask

    task automatic rd8(input logic [4:0] i, output logic [7:0] v);
        rd_a_idx = i; #1; v = rd_a_data;
    endtask

    task automatic rd16(input logic [4:0] i, output logic [15:0] v);
        rd_w_idx = i; #1; v = rd_w_data;
    endtask

    task automatic t_reset();
        logic [7:0] v;
        for (int i = 0; i < 32; i++) begin
            rd8(5'(i), v);
            chk("R1", "reg after reset", {8'h0, v}, 16'h0000);
        end
        w8(5'd0, 8'hFF); w8(5'd31, 8'h80);
        rst = 1'b1; edge_n(); rst = 1'b0;
        rd8(5'd0, v);  chk("R1", "r0 after second reset", {8'h0, v}, 16'h0000);
        rd8(5'd31, v); chk("R1", "r31 after second reset", {8'h0, v}, 16'h0000);
    endtask

    task automatic t_byte_rw();
        logic [7:0] v;
        w8(5'd3, 8'h5A); w8(5'd17, 8'hA5);
        rd_a_idx = 5'd3; rd_b_idx = 5'd17; #1;
        chk("R3", "port A r3", {8'h0, rd_a_data}, 16'h005A);
        chk("R2", "port B r17", {8'h0, rd_b_data}, 16'h00A5);
        rd_a_idx = 5'd17; rd_b_idx = 5'd17; #1;
        chk("R2", "both ports same reg", {rd_a_data, rd_b_data}, 16'hA5A5);
        wr_en = 1'b1; wr_idx = 5'd3; wr_data = 8'hC3;
        rd_a_idx = 5'd3; #1;
        chk("R2", "old value during write", {8'h0, rd_a_data}, 16'h005A);
        edge_n(); clear_inputs();
        rd8(5'd3, v); chk("R3", "r3 after write", {8'h0, v}, 16'h00C3);
    endtask

    task automatic t_pair_rw();
        logic [7:0] v; logic [15:0] p;
        w16(5'd4, 16'hBEEF);
        rd8(5'd4, v); chk("R4", "low byte r4", {8'h0, v}, 16'h00EF);
        rd8(5'd5, v); chk("R4", "high byte r5", {8'h0, v}, 16'h00BE);
        rd16(5'd4, p); chk("R6", "pair read even", p, 16'hBEEF);
        rd16(5'd5, p); chk("R6", "pair read odd index", p, 16'hBEEF);
    endtask

    task automatic t_odd_pair();
        logic [7:0] v;
        w8(5'd7, 8'h11); w8(5'd8, 8'h22); w8(5'd6, 8'h33);
        wr16_en = 1'b1; wr16_idx = 5'd7; wr16_data = 16'h1234; #1;
        chk("R5", "pair_err on odd", {15'h0, pair_err}, 16'h0001);
        edge_n(); clear_inputs(); #1;
        chk("R5", "pair_err idle", {15'h0, pair_err}, 16'h0000);
        rd8(5'd6, v); chk("R5", "r6 untouched", {8'h0, v}, 16'h0033);
        rd8(5'd7, v); chk("R5", "r7 untouched", {8'h0, v}, 16'h0011);
        rd8(5'd8, v); chk("R5", "r8 untouched", {8'h0, v}, 16'h0022);
    endtask

    task automatic t_dbus();
        logic [7:0] v;
        dbus_addr = 16'h0009; dbus_we = 1'b1; dbus_wdata = 8'h77;
        edge_n(); clear_inputs();
        rd8(5'd9, v); chk("R7", "bus write lands", {8'h0, v}, 16'h0077);
        dbus_addr = 16'h0009; #1;
        chk("R7", "bus hit in window", {15'h0, dbus_hit}, 16'h0001);
        chk("R7", "bus read r9", {8'h0, dbus_rdata}, 16'h0077);
        dbus_addr = 16'h001F; #1;
        chk("R7", "bus hit at 0x1F", {15'h0, dbus_hit}, 16'h0001);
        dbus_addr = 16'h0029; dbus_we = 1'b1; dbus_wdata = 8'h99; #1;
        chk("R7", "no hit outside", {15'h0, dbus_hit}, 16'h0000);
        chk("R7", "rdata zero outside", {8'h0, dbus_rdata}, 16'h0000);
        edge_n(); clear_inputs();
        rd8(5'd9, v); chk("R7", "outside write ignored", {8'h0, v}, 16'h0077);
        dbus_addr = 16'h0020; #1;
        chk("R7", "no hit at 0x20", {15'h0, dbus_hit}, 16'h0000);
    endtask

    task automatic ptr_go(input logic [1:0] s, input logic [1:0] m,
                          input logic [5:0] d);
        ptr_en = 1'b1; ptr_sel = s; ptr_mode = m; ptr_disp = d; #1;
    endtask

    task automatic t_pointers();
        logic [15:0] p;
        w16(5'd26, 16'h00FF); w16(5'd28, 16'h1000); w16(5'd30, 16'h0200);
        ptr_go(2'd0, 2'd1, 6'd0);
        chk("R9", "postinc addr", ptr_addr, 16'h00FF);
        edge_n(); clear_inputs();
        rd16(5'd26, p); chk("R9", "postinc carry", p, 16'h0100);
        ptr_go(2'd1, 2'd2, 6'd0);
        chk("R10", "predec addr", ptr_addr, 16'h0FFF);
        edge_n(); clear_inputs();
        rd16(5'd28, p); chk("R10", "predec borrow", p, 16'h0FFF);
        ptr_go(2'd2, 2'd3, 6'd63);
        chk("R11", "disp addr", ptr_addr, 16'h023F);
        edge_n(); clear_inputs();
        rd16(5'd30, p); chk("R11", "disp leaves Z", p, 16'h0200);
        ptr_go(2'd2, 2'd0, 6'd5);
        chk("R11", "plain addr", ptr_addr, 16'h0200);
        edge_n(); clear_inputs();
        rd16(5'd30, p); chk("R11", "plain leaves Z", p, 16'h0200);
        ptr_go(2'd3, 2'd1, 6'd0);
        chk("R8", "sel none addr", ptr_addr, 16'h0000);
        edge_n(); clear_inputs();
        rd16(5'd26, p); chk("R8", "sel none X kept", p, 16'h0100);
        rd16(5'd28, p); chk("R8", "sel none Y kept", p, 16'h0FFF);
        rd16(5'd30, p); chk("R8", "sel none Z kept", p, 16'h0200);
        ptr_en = 1'b0; ptr_sel = 2'd0; ptr_mode = 2'd0; #1;
        chk("R8", "disabled addr", ptr_addr, 16'h0000);
        w16(5'd26, 16'hFFFF);
        ptr_go(2'd0, 2'd1, 6'd0);
        edge_n(); clear_inputs();
        rd16(5'd26, p); chk("R9", "postinc wrap", p, 16'h0000);
    endtask

    task automatic t_priority();
        logic [7:0] v; logic [15:0] p;
        wr_en = 1'b1; wr_idx = 5'd10; wr_data = 8'hAA;
        dbus_we = 1'b1; dbus_addr = 16'h000A; dbus_wdata = 8'h55;
        edge_n(); clear_inputs();
        rd8(5'd10, v); chk("R12", "byte beats bus", {8'h0, v}, 16'h00AA);
        wr16_en = 1'b1; wr16_idx = 5'd10; wr16_data = 16'h1234;
        wr_en = 1'b1; wr_idx = 5'd11; wr_data = 8'h99;
        edge_n(); clear_inputs();
        rd16(5'd10, p); chk("R12", "byte beats pair", p, 16'h9934);
        ptr_go(2'd0, 2'd1, 6'd0);
        dbus_we = 1'b1; dbus_addr = 16'h001A; dbus_wdata = 8'hEE;
        edge_n(); clear_inputs();
        rd16(5'd26, p); chk("R12", "pointer beats bus", p, 16'h0001);
        ptr_go(2'd0, 2'd1, 6'd0);
        wr16_en = 1'b1; wr16_idx = 5'd26; wr16_data = 16'hCAFE;
        edge_n(); clear_inputs();
        rd16(5'd26, p); chk("R12", "pair beats pointer", p, 16'hCAFE);
    endtask

    initial begin
        repeat (3) edge_n();
        rst = 1'b0;
        t_reset();
        t_byte_rw();
        t_pair_rw();
        t_odd_pair();
        t_dbus();
        t_pointers();
        t_priority();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule